// File: doc/BRIEF.md
# Packet Payload XOR Cipher Stage

This stage sits in a 64-bit packet pipeline. It hides the payload of IPv4 packets by XORing every byte after the Ethernet and IPv4 headers with a key pattern, and it leaves those headers readable so the packet can still be routed. Running a packet through the stage twice with the same key gives back the original bytes, so one instance serves as both encryptor and decryptor. Every packet is taken to be IPv4 with no options. No protocol check is made.

Words enter through a data/ctrl/write/ready handshake and are held in a small fall-through FIFO. A word is presented downstream in the cycle that follows its acceptance, as soon as the downstream ready allows it. A nonzero ctrl word that comes before packet data is a module header and is forwarded untouched. Data words carry ctrl of zero. A nonzero ctrl after data marks the final word of the packet. The 32-bit key is loaded through a one-word write port. A copy of the key is taken when each packet's first data word leaves the FIFO, so a write during a packet only affects the next packet.

Top module: `pyld_xor_stage`

## Requirements
- R1: Byte lanes are counted from the most significant lane, which carries the first packet byte. Data word 5 and every later data word of a packet leave with all 64 bits XORed with the mask {key, key}, where the key is the packet's latched 32-bit key.
- R2: The first four data words of a packet (packet bytes 1 to 32) leave unchanged.
- R3: A word with nonzero ctrl that arrives while no packet is in progress is a module header and leaves unchanged. Any number of such words may precede a packet.
- R4: In data word 4 (packet bytes 33 to 40), bits 63:48 (bytes 33 and 34) leave unchanged and bits 47:0 are XORed with the low 48 bits of the mask.
- R5: The key is latched when a packet's first data word leaves. A key write made after that point has no effect until the next packet.
- R6: out_wr is asserted only while out_rdy is high. Every accepted word leaves exactly once and in order, whatever stalls occur.
- R7: out_ctrl always equals the ctrl of the word being sent.
- R8: A word is accepted only when in_wr and in_rdy are both high. in_rdy is low while the FIFO holds FIFO_DEPTH (4) words.
- R9: A nonzero ctrl after the packet's data words marks the last data word, and that word is treated by its position. The next word starts header handling, and back-to-back packets need no idle cycle.
- R10: After reset, in_rdy is 1, out_wr is 0 and the key is zero, so packets pass unchanged until a key is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 64 | Incoming word |
| in_ctrl | input | 8 | Incoming word control tag |
| in_wr | input | 1 | Upstream offers a word |
| in_rdy | output | 1 | Stage can take a word |
| out_data | output | 64 | Outgoing word, masked as required |
| out_ctrl | output | 8 | Outgoing control tag |
| out_wr | output | 1 | Outgoing word valid this cycle |
| out_rdy | input | 1 | Downstream can take a word |
| key_wr_en | input | 1 | Load the key register |
| key_wr_data | input | 32 | New key value |

## Verification
A wrong packet-position state shows at the ports in the first word it touches. It either masks bytes 33 and 34 or a header word, or it leaves payload bytes clear, and the bench's position-aware model flags that word. A lost or duplicated FIFO entry shifts every later word, so the in-order comparison fails on the next transfer. A key captured at the wrong time shows only from data word 4 onward, and it is exposed by the directed test that writes a new key in the middle of a packet.

// File: rtl/xs_pkg.sv
// Shared types for the payload XOR stage.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package xs_pkg;
    // Position of the next word to leave, relative to the current packet
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,   // outside a packet: module headers or first data word
        ST_HEAD = 2'd1,   // inside the plaintext header words
        ST_EDGE = 2'd2,   // the word holding the plaintext/cipher boundary
        ST_BODY = 2'd3    // fully masked payload words
    } xs_state_t;
endpackage

// File: rtl/xs_fifo.sv
// Fall-through FIFO: the head entry is visible without a read request.
// Assumes: DEPTH is a power of two; push is never asserted while full.
module xs_fifo #(
    parameter int W     = 72,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt_q;

    // Storage write: capture the pushed word at the write pointer
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            if (push && !pop)      cnt_q <= cnt_q + CNT_W'(1);
            else if (pop && !push) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign count = cnt_q;
endmodule

// File: rtl/xs_keyreg.sv
// Software-loaded key register, cleared by reset.
// Assumes: a single writer presents key data with a one-cycle enable.
module xs_keyreg #(
    parameter int KEY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_data,
    output logic [KEY_W-1:0] key
);
    // Hold the last written key
    always_ff @(posedge clk) begin
        if (!rst_n)     key <= '0;
        else if (wr_en) key <= wr_data;
    end
endmodule

// File: rtl/xs_ctl.sv
// Packet position tracker: walks headers, plaintext words, the boundary
// word and the payload, and emits a per-byte-lane encrypt enable.
// Assumes: ctrl != 0 before data is a module header; ctrl != 0 after data
// is the last word; EDGE_WORD >= 1. Lane BYTES-1 is the first byte.
module xs_ctl
    import xs_pkg::*;
#(
    parameter int BYTES     = 8,
    parameter int KEY_W     = 32,
    parameter int EDGE_WORD = 4,
    parameter int EDGE_KEEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             head_is_ctl,
    input  logic [KEY_W-1:0] key_now,
    output logic [BYTES-1:0] lane_en,
    output logic [KEY_W-1:0] pkt_key,
    output xs_state_t        state
);
    localparam int IDX_W = $clog2(EDGE_WORD + 1);

    xs_state_t        state_q;
    logic [IDX_W-1:0] idx_q;
    logic [BYTES-1:0] edge_pat;

    // Boundary-word lane pattern: the first EDGE_KEEP lanes stay clear
    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            edge_pat[i] = ((BYTES - 1 - i) >= EDGE_KEEP);
        end
    end

    // Lane enable for the word now at the FIFO head
    always_comb begin
        unique case (state_q)
            ST_BODY: lane_en = '1;
            ST_EDGE: lane_en = edge_pat;
            default: lane_en = '0;
        endcase
    end

    // Position state and data-word index advance on each popped word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HDR;
            idx_q   <= '0;
        end else if (pop) begin
            unique case (state_q)
                ST_HDR: begin
                    if (!head_is_ctl) begin
                        idx_q   <= IDX_W'(1);
                        state_q <= (EDGE_WORD == 1) ? ST_EDGE : ST_HEAD;
                    end
                end
                ST_HEAD: begin
                    idx_q <= idx_q + IDX_W'(1);
                    if (head_is_ctl)                           state_q <= ST_HDR;
                    else if (idx_q == IDX_W'(EDGE_WORD - 1))   state_q <= ST_EDGE;
                end
                ST_EDGE: state_q <= head_is_ctl ? ST_HDR : ST_BODY;
                default: if (head_is_ctl) state_q <= ST_HDR;
            endcase
        end
    end

    // Per-packet key copy, taken as the first data word leaves
    always_ff @(posedge clk) begin
        if (!rst_n)                                    pkt_key <= '0;
        else if (pop && state_q == ST_HDR && !head_is_ctl) pkt_key <= key_now;
    end

    assign state = state_q;
endmodule

// File: rtl/xs_lane_xor.sv
// Byte-lane XOR: lanes with their enable set are XORed with the
// replicated key, the rest pass through.
// Assumes: DATA_W is a multiple of KEY_W and of 8.
module xs_lane_xor #(
    parameter int DATA_W = 64,
    parameter int KEY_W  = 32
) (
    input  logic [DATA_W-1:0]   din,
    input  logic [DATA_W/8-1:0] lane_en,
    input  logic [KEY_W-1:0]    key,
    output logic [DATA_W-1:0]   dout
);
    localparam int BYTES = DATA_W / 8;
    localparam int REP   = DATA_W / KEY_W;

    logic [DATA_W-1:0] pad;
    assign pad = {REP{key}};

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign dout[8*b +: 8] = lane_en[b] ? (din[8*b +: 8] ^ pad[8*b +: 8])
                                           : din[8*b +: 8];
    end
endmodule

// File: rtl/pyld_xor_stage.sv
// Payload XOR cipher stage: buffers words in a fall-through FIFO and XORs
// the IPv4 payload with the latched key while headers pass unchanged.
// Assumes: upstream writes only while in_rdy is high; IPv4 without options.
module pyld_xor_stage
    import xs_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int CTRL_W     = 8,
    parameter int KEY_W      = 32,
    parameter int CLEAR_B    = 34,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CTRL_W-1:0] in_ctrl,
    input  logic              in_wr,
    output logic              in_rdy,
    output logic [DATA_W-1:0] out_data,
    output logic [CTRL_W-1:0] out_ctrl,
    output logic              out_wr,
    input  logic              out_rdy,
    input  logic              key_wr_en,
    input  logic [KEY_W-1:0]  key_wr_data
);
    localparam int BYTES     = DATA_W / 8;
    localparam int EDGE_WORD = CLEAR_B / BYTES;
    localparam int EDGE_KEEP = CLEAR_B % BYTES;
    localparam int ENT_W     = CTRL_W + DATA_W;
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);

    logic              push;
    logic              pop;
    logic              fifo_full;
    logic              fifo_empty;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [ENT_W-1:0]  head;
    logic [DATA_W-1:0] head_data;
    logic [CTRL_W-1:0] head_ctrl;
    logic [KEY_W-1:0]  key_q;
    logic [KEY_W-1:0]  pkt_key;
    logic [BYTES-1:0]  lane_en;
    xs_state_t         cur_state;

    assign push      = in_wr && !fifo_full;
    assign pop       = !fifo_empty && out_rdy;
    assign in_rdy    = !fifo_full;
    assign head_data = head[DATA_W-1:0];
    assign head_ctrl = head[ENT_W-1:DATA_W];

    xs_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({in_ctrl, in_data}),
        .pop       (pop),
        .head      (head),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .count     (fifo_cnt)
    );

    xs_keyreg #(.KEY_W(KEY_W)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (key_wr_en),
        .wr_data (key_wr_data),
        .key     (key_q)
    );

    xs_ctl #(
        .BYTES     (BYTES),
        .KEY_W     (KEY_W),
        .EDGE_WORD (EDGE_WORD),
        .EDGE_KEEP (EDGE_KEEP)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop         (pop),
        .head_is_ctl (|head_ctrl),
        .key_now     (key_q),
        .lane_en     (lane_en),
        .pkt_key     (pkt_key),
        .state       (cur_state)
    );

    xs_lane_xor #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_xor (
        .din     (head_data),
        .lane_en (lane_en),
        .key     (pkt_key),
        .dout    (out_data)
    );

    assign out_ctrl = head_ctrl;
    assign out_wr   = pop;
endmodule

// File: rtl/xs_chk.sv
// Property checker for the payload XOR stage, bound to the top module.
module xs_chk
    import xs_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int CTRL_W     = 8,
    parameter int KEY_W      = 32,
    parameter int CLEAR_B    = 34,
    parameter int FIFO_DEPTH = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_rdy,
    input logic                           out_wr,
    input logic                           out_rdy,
    input logic [DATA_W-1:0]              out_data,
    input logic [CTRL_W-1:0]              out_ctrl,
    input logic [DATA_W-1:0]              head_data,
    input logic [CTRL_W-1:0]              head_ctrl,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
    input logic [KEY_W-1:0]               pkt_key,
    input xs_state_t                      cur_state
);
    localparam int KEEP_BYTES = CLEAR_B % (DATA_W / 8);
    localparam logic [DATA_W-1:0] KEEP_MASK = ~({DATA_W{1'b1}} >> (8 * KEEP_BYTES));

    a_r3_header_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && cur_state == ST_HDR && out_ctrl != '0) |-> out_data == head_data);

    a_r2_head_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && cur_state == ST_HEAD) |-> out_data == head_data);

    a_r4_edge_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && cur_state == ST_EDGE) |-> ((out_data ^ head_data) & KEEP_MASK) == '0);

    a_r5_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state != ST_HDR && $past(cur_state != ST_HDR)) |-> $stable(pkt_key));

    a_r6_wr_needs_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        !out_rdy |-> !out_wr);

    a_r7_ctrl_pass: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> out_ctrl == head_ctrl);

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH)) &&
        ((fifo_cnt == ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH)) -> !in_rdy));

    a_r10_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_wr && in_rdy));
endmodule

bind pyld_xor_stage xs_chk #(
    .DATA_W     (DATA_W),
    .CTRL_W     (CTRL_W),
    .KEY_W      (KEY_W),
    .CLEAR_B    (CLEAR_B),
    .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_rdy    (in_rdy),
    .out_wr    (out_wr),
    .out_rdy   (out_rdy),
    .out_data  (out_data),
    .out_ctrl  (out_ctrl),
    .head_data (head_data),
    .head_ctrl (head_ctrl),
    .fifo_cnt  (fifo_cnt),
    .pkt_key   (pkt_key),
    .cur_state (cur_state)
);

// File: tb/pyld_xor_stage_tb.sv
module pyld_xor_stage_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        in_wr = 1'b0;
    logic        in_rdy;
    logic [63:0] out_data;
    logic [7:0]  out_ctrl;
    logic        out_wr;
    logic        out_rdy = 1'b0;
    logic        key_wr_en = 1'b0;
    logic [31:0] key_wr_data = '0;

    int checks = 0;
    int errors = 0;
    bit hold_stall = 1'b0;
    bit full_rate = 1'b1;
    bit done = 1'b0;

    logic [63:0] exp_d[$];
    logic [7:0]  exp_c[$];
    string       exp_t[$];

    bit          m_in_pkt = 1'b0;
    int          m_idx = 0;
    logic [31:0] m_key = '0;
    logic [31:0] m_pkt_key = '0;
    string       m_tag = "";

    always #5 clk = ~clk;

    pyld_xor_stage u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_ctrl(in_ctrl), .in_wr(in_wr), .in_rdy(in_rdy),
        .out_data(out_data), .out_ctrl(out_ctrl), .out_wr(out_wr), .out_rdy(out_rdy),
        .key_wr_en(key_wr_en), .key_wr_data(key_wr_data)
    );

    // Expected output word from packet position rules (R1..R4, R9)
    function automatic logic [63:0] model(input logic [63:0] d, input logic [7:0] c);
        logic [63:0] m;
        logic [63:0] r;
        if (!m_in_pkt) begin
            if (c != 0) begin m_tag = "R3"; return d; end
            m_in_pkt = 1'b1;
            m_pkt_key = m_key;
            m_idx = 1;
            m_tag = "R2";
            return d;
        end
        m = {m_pkt_key, m_pkt_key};
        if (m_idx < 4)       begin r = d;                                  m_tag = "R2"; end
        else if (m_idx == 4) begin r = d ^ (m & 64'h0000_FFFF_FFFF_FFFF); m_tag = "R4"; end
        else                 begin r = d ^ m;                              m_tag = "R1"; end
        m_idx++;
        if (c != 0) m_in_pkt = 1'b0;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offer one word, holding it until accepted (R8)
    task automatic send(input logic [63:0] d, input logic [7:0] c);
        bit ok;
        exp_d.push_back(model(d, c));
        exp_c.push_back(c);
        exp_t.push_back(m_tag);
        in_data = d;
        in_ctrl = c;
        in_wr = 1'b1;
        forever begin
            ok = in_rdy;
            @(posedge clk);
            @(negedge clk);
            if (ok) break;
        end
    endtask

    task automatic idle();
        in_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_pkt(input int nh, input int nd, input bit gaps);
        for (int i = 0; i < nh; i++) begin
            send({$urandom, $urandom}, 8'(1 + ($urandom % 255)));
            if (gaps && ($urandom % 4 == 0)) idle();
        end
        for (int i = 0; i < nd; i++) begin
            send({$urandom, $urandom}, (i == nd - 1) ? 8'(1 + ($urandom % 255)) : 8'h00);
            if (gaps && ($urandom % 4 == 0)) idle();
        end
    endtask

    task automatic drain();
        in_wr = 1'b0;
        while (exp_d.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic write_key(input logic [31:0] k);
        key_wr_en = 1'b1;
        key_wr_data = k;
        @(posedge clk);
        @(negedge clk);
        key_wr_en = 1'b0;
        m_key = k;
    endtask

    // Output side: set ready, then compare the word about to transfer
    initial begin
        forever begin
            @(negedge clk);
            out_rdy = hold_stall ? 1'b0 : (full_rate ? 1'b1 : ($urandom % 3 != 0));
            #1;
            if (rst_n && out_wr) begin
                if (!out_rdy) check(1'b0, "R6 write without ready", 64'(out_wr), 64'd0);
                if (exp_d.size() == 0) begin
                    check(1'b0, "R6 extra word", out_data, 64'd0);
                end else begin
                    logic [63:0] ed;
                    logic [7:0]  ec;
                    string       et;
                    ed = exp_d.pop_front();
                    ec = exp_c.pop_front();
                    et = exp_t.pop_front();
                    check(out_data === ed, et, out_data, ed);
                    check(out_ctrl === ec, "R7", 64'(out_ctrl), 64'(ec));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R10: idle outputs after reset
        check(in_rdy === 1'b1, "R10 in_rdy", 64'(in_rdy), 64'd1);
        check(out_wr === 1'b0, "R10 out_wr", 64'(out_wr), 64'd0);
        @(negedge clk);

        // R10: key unwritten so payload is unchanged
        send_pkt(1, 7, 1'b0);
        drain();

        // R1 R2 R4: directed packet with two headers and a long payload
        write_key(32'hA5C3_1E7F);
        send_pkt(2, 9, 1'b0);
        drain();

        // R1: running the encrypted output back through restores the input
        begin
            logic [63:0] orig [7];
            logic [63:0] enc [7];
            for (int i = 0; i < 7; i++) orig[i] = {$urandom, $urandom};
            send(64'h1111, 8'hFF);
            for (int i = 0; i < 7; i++) begin
                enc[i] = exp_d[exp_d.size() - 1];
                send(orig[i], (i == 6) ? 8'h01 : 8'h00);
                enc[i] = exp_d[exp_d.size() - 1];
            end
            drain();
            send(64'h2222, 8'hFF);
            for (int i = 0; i < 7; i++) begin
                send(enc[i], (i == 6) ? 8'h01 : 8'h00);
                check(exp_d[exp_d.size() - 1] === orig[i], "R1 involution", exp_d[exp_d.size() - 1], orig[i]);
            end
            drain();
        end

        // R9: short packet, packet ending on boundary word, back to back
        send_pkt(1, 2, 1'b0);
        send_pkt(3, 5, 1'b0);
        send_pkt(1, 6, 1'b0);
        drain();

        // R5: key write after first data word has left
        send(64'hDEAD_0001, 8'h40);
        send(64'h0123_4567_89AB_CDEF, 8'h00);
        send(64'h0F0F_0F0F_0F0F_0F0F, 8'h00);
        in_wr = 1'b0;
        repeat (4) @(negedge clk);
        write_key(32'h0BAD_F00D);
        m_key = m_key;
        for (int i = 0; i < 6; i++) send({$urandom, $urandom}, (i == 5) ? 8'h02 : 8'h00);
        drain();
        // R5: next packet uses the new key
        send_pkt(1, 8, 1'b0);
        drain();

        // R8: stall output and fill the FIFO
        hold_stall = 1'b1;
        @(negedge clk);
        send(64'h0000_0000_0000_0AAA, 8'h10);
        send(64'h0000_0000_0000_0BBB, 8'h00);
        send(64'h0000_0000_0000_0CCC, 8'h00);
        send(64'h0000_0000_0000_0DDD, 8'h00);
        in_wr = 1'b0;
        #2;
        check(in_rdy === 1'b0, "R8 full", 64'(in_rdy), 64'd0);
        check(out_wr === 1'b0, "R6 stalled", 64'(out_wr), 64'd0);
        @(negedge clk);
        hold_stall = 1'b0;
        for (int i = 0; i < 6; i++) send({$urandom, $urandom}, (i == 5) ? 8'h03 : 8'h00);
        drain();

        // R6 R9: random stalls, gaps and lengths
        full_rate = 1'b0;
        for (int p = 0; p < 60; p++) begin
            if (p % 6 == 0) begin
                drain();
                write_key($urandom);
            end
            send_pkt(1 + ($urandom % 3), 2 + ($urandom % 11), 1'b1);
        end
        drain();
        full_rate = 1'b1;

        // R6: nothing left over
        check(exp_d.size() == 0, "R6 leftover", 64'(exp_d.size()), 64'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule